// File: doc/BRIEF.md
# Product Register Shift Mode Unit

This block scales the 32-bit product of a multiply before the value is passed on to the arithmetic unit or stored. The amount and direction of the scaling come from a 3-bit shift-mode field kept in a register inside the block. That register is loaded from bits 9 down to 7 of a 16-bit status word whenever a write strobe is high at a clock edge. The shifted result is purely combinational from the current product value, the stored mode and an addressing-mode input.

The modes cover a one-bit left shift, a straight pass, and arithmetic right shifts of one to six places. The left shift by one is the mode the register holds after reset. A high addressing-mode input changes one code, 101, from a right shift by four into a left shift by four. Left shifts discard the bits that leave the top of the word and never saturate.

Reset is asynchronous and active low, and its release is synchronised to the clock inside the block. Status bits other than the mode field reach the write port but this block ignores them.

Top module: `prod_shift_unit`

## Requirements
- R1: While reset is held and after it is released, the mode register holds code 000, so the output is the product shifted left by one until the first write.
- R2: With mode code 000 the output is the product shifted left by one place. Bit 0 is zero and the old bit 31 is dropped.
- R3: With mode code 001 the output equals the product unchanged.
- R4: With mode codes 010, 011, 100, 101, 110 and 111 the output is the product shifted right by 1, 2, 3, 4, 5 and 6 places. Each of these shifts copies bit 31 into the vacated top bits and drops the low bits.
- R5: When addr_mode is 1 and the mode code is 101, the output is the product shifted left by four places. The low four bits are zero and bits shifted past bit 31 are lost. For every other code, addr_mode has no effect.
- R6: When wr_en is 1 at a rising clock edge, the mode register takes wr_word[9:7]. When wr_en is 0, the mode register keeps its value whatever wr_word holds.
- R7: Bits 15:10 and 6:0 of wr_word have no effect on the stored mode or on the output.
- R8: The output follows changes of prod_in and addr_mode in the same cycle, with no register between them. A written mode takes effect in the output right after the loading edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| wr_en | input | 1 | Write strobe for the shift-mode field |
| wr_word | input | 16 | Status word; bits 9:7 carry the new mode code |
| addr_mode | input | 1 | Addressing-mode bit; turns code 101 into a left shift by four |
| prod_in | input | 32 | Product register value |
| prod_out | output | 32 | Shifted product |

## Verification
On every cycle the assertions check four things about the output and the mode register:
- the reset value of the mode register, and that it loads only on a write strobe and holds otherwise;
- the exact result of the pass code and of the left-by-one code;
- the sign copy that the deepest right shift produces;
- the zero low nibble of the left-by-four case.

The exact results of the intermediate right shifts need the bench. So do the claims that status bits outside the field and the addressing-mode bit on other codes have no effect. The bench covers these with directed sweeps of every code under both addressing modes, using values at the sign boundary, and with seeded random traffic that mixes writes with idle cycles.

// File: rtl/psu_pkg.sv
package psu_pkg;
  localparam int PSU_DW     = 32;
  localparam int PSU_SW     = 16;
  localparam int PSU_MW     = 3;
  localparam int PSU_FLD_LO = 7;
  localparam logic [PSU_MW-1:0] PSU_RESET_CODE = 3'b000;
  localparam logic [PSU_MW-1:0] PSU_ALT_CODE   = 3'b101;
  localparam int PSU_ALT_LSH = 4;
endpackage

// File: rtl/psu_rst_sync.sv
module psu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/psu_mode_reg.sv
module psu_mode_reg #(
  parameter int SW = psu_pkg::PSU_SW,
  parameter int MW = psu_pkg::PSU_MW,
  parameter int FLD_LO = psu_pkg::PSU_FLD_LO,
  parameter logic [MW-1:0] RESET_CODE = psu_pkg::PSU_RESET_CODE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_word,
  output logic [MW-1:0] mode_q
);
  localparam int FLD_HI = FLD_LO + MW - 1;

  logic [MW-1:0] mode_d;

  // next-state: load the field on a strobe, otherwise hold
  always_comb begin
    mode_d = mode_q;
    if (wr_en) mode_d = wr_word[FLD_HI:FLD_LO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= RESET_CODE;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/psu_shifter.sv
module psu_shifter #(
  parameter int DW = psu_pkg::PSU_DW,
  parameter int MW = psu_pkg::PSU_MW,
  parameter logic [MW-1:0] ALT_CODE = psu_pkg::PSU_ALT_CODE,
  parameter int ALT_LSH = psu_pkg::PSU_ALT_LSH
) (
  input  logic [DW-1:0] prod_i,
  input  logic [MW-1:0] mode_i,
  input  logic          alt_i,
  output logic [DW-1:0] prod_o
);
  localparam int NCODES = 1 << MW;

  logic [DW-1:0] cand [NCODES];
  logic [DW-1:0] cand_alt;

  // code 0: left by one, code 1: pass, code c>=2: arithmetic right by c-1
  for (genvar c = 0; c < NCODES; c++) begin : g_code
    localparam int RSH = (c >= 2) ? c - 1 : 0;
    if (c == 0) begin : g_lsh1
      assign cand[c] = {prod_i[DW-2:0], 1'b0};
    end else if (c == 1) begin : g_pass
      assign cand[c] = prod_i;
    end else begin : g_rsh
      assign cand[c] = DW'($signed(prod_i) >>> RSH);
    end
  end

  assign cand_alt = prod_i << ALT_LSH;

  always_comb begin
    if (alt_i && (mode_i == ALT_CODE)) prod_o = cand_alt;
    else                               prod_o = cand[mode_i];
  end
endmodule

// File: rtl/prod_shift_unit.sv
module prod_shift_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_word,
  input  logic        addr_mode,
  input  logic [31:0] prod_in,
  output logic [31:0] prod_out
);
  import psu_pkg::*;

  logic              rst_sync_n;
  logic [PSU_MW-1:0] mode_q;

  psu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  psu_mode_reg #(
    .SW(PSU_SW), .MW(PSU_MW), .FLD_LO(PSU_FLD_LO), .RESET_CODE(PSU_RESET_CODE)
  ) u_mode (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_word (wr_word),
    .mode_q  (mode_q)
  );

  psu_shifter #(
    .DW(PSU_DW), .MW(PSU_MW), .ALT_CODE(PSU_ALT_CODE), .ALT_LSH(PSU_ALT_LSH)
  ) u_shift (
    .prod_i (prod_in),
    .mode_i (mode_q),
    .alt_i  (addr_mode),
    .prod_o (prod_out)
  );
endmodule

// File: rtl/psu_checker.sv
module psu_checker (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        wr_en,
  input logic [15:0] wr_word,
  input logic        addr_mode,
  input logic [2:0]  mode_q,
  input logic [31:0] prod_in,
  input logic [31:0] prod_out
);
  // R1: mode register sits at the reset code while reset is applied
  assert_reset_code_R1: assert property (@(posedge clk)
    !rst_sync_n |-> mode_q == 3'b000);

  // R2: left by one keeps bits 30:0 in 31:1 and zeroes bit 0
  assert_lsh1_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_q == 3'b000 |-> (prod_out[31:1] == prod_in[30:0]) && !prod_out[0]);

  // R3: pass code
  assert_pass_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_q == 3'b001 |-> prod_out == prod_in);

  // R4: deepest right shift fills seven top bits with the sign
  assert_rsh6_sign_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_q == 3'b111 |-> prod_out[31:25] == {7{prod_in[31]}});

  // R5: alternate left by four leaves a zero low nibble
  assert_alt_lsh4_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr_mode && mode_q == 3'b101) |-> prod_out[3:0] == 4'h0);

  // R6: load on strobe, hold otherwise
  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |=> mode_q == $past(wr_word[9:7]));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> $stable(mode_q));
endmodule

bind prod_shift_unit psu_checker u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_word    (wr_word),
  .addr_mode  (addr_mode),
  .mode_q     (mode_q),
  .prod_in    (prod_in),
  .prod_out   (prod_out)
);

// File: tb/prod_shift_unit_test.sv
module prod_shift_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_word;
  logic        addr_mode;
  logic [31:0] prod_in;
  logic [31:0] prod_out;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  logic [2:0] model_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  prod_shift_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .addr_mode(addr_mode), .prod_in(prod_in), .prod_out(prod_out)
  );

  function automatic logic [31:0] expect_out(logic [31:0] p, logic [2:0] m, logic am);
    logic signed [31:0] s;
    s = p;
    case (m)
      3'b000: return {p[30:0], 1'b0};
      3'b001: return p;
      3'b101: return am ? {p[27:0], 4'h0} : 32'(s >>> 4);
      default: return 32'(s >>> (int'(m) - 1));
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s mode=%0d am=%0b in=%h act=%h exp=%h",
               tag, model_mode, addr_mode, prod_in, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample a quarter period after the rising edge
  task automatic step(logic we, logic [15:0] w, logic am, logic [31:0] p, string tag);
    @(negedge clk);
    wr_en = we; wr_word = w; addr_mode = am; prod_in = p;
    @(posedge clk);
    if (we) model_mode = w[9:7];
    #(CLK_PERIOD/4);
    check(tag, prod_out, expect_out(p, model_mode, am));
  endtask

  function automatic logic [15:0] word_for(logic [2:0] m, logic [15:0] junk);
    logic [15:0] w;
    w = junk;
    w[9:7] = m;
    return w;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    rst_n = 1'b0; wr_en = 1'b0; wr_word = '0; addr_mode = 1'b0;
    prod_in = 32'hC000_0003; model_mode = 3'b000;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 during reset", prod_out, 32'h8000_0006);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 after release", prod_out, 32'h8000_0006);

    // R2: MSB dropped, zero fill
    step(1'b0, 16'hFFFF, 1'b0, 32'hFFFF_FFFF, "R2 lsh1 all ones");
    step(1'b0, 16'h0000, 1'b1, 32'h8000_0001, "R2 R5 lsh1 with addr_mode");

    // sweep every code under both addressing modes with boundary values
    for (int m = 0; m < 8; m++) begin
      step(1'b1, word_for(3'(m), 16'h0000), 1'b0, 32'h8000_0001, "R6 R4 sweep load");
      step(1'b0, 16'hFFFF, 1'b0, 32'h7FFF_FFFF, "R3 R4 sweep positive");
      step(1'b0, 16'h1234, 1'b1, 32'hF000_0010, "R5 sweep addr_mode");
      step(1'b0, 16'h0000, 1'b1, 32'h8765_4321, "R5 R8 sweep mixed");
    end

    // R5: left by four drops top bits, no saturation
    step(1'b1, word_for(3'b101, 16'h0000), 1'b1, 32'h7FFF_FFFF, "R5 lsh4 overflow");
    check("R5 lsh4 value", prod_out, 32'hFFFF_FFF0);
    step(1'b0, 16'h0000, 1'b0, 32'h8000_0000, "R4 rsh4 negative");
    check("R4 rsh4 value", prod_out, 32'hF800_0000);

    // R7: junk outside 9:7 must not disturb the mode
    step(1'b1, word_for(3'b001, 16'hFC7F), 1'b0, 32'hDEAD_BEEF, "R7 junk bits pass code");
    check("R7 pass value", prod_out, 32'hDEAD_BEEF);
    step(1'b1, word_for(3'b111, 16'hFC7F), 1'b0, 32'h8000_0000, "R7 junk bits rsh6");
    check("R7 rsh6 value", prod_out, 32'hFE00_0000);

    // R6: without a strobe the mode holds despite data
    step(1'b0, word_for(3'b000, 16'h0000), 1'b0, 32'h0000_0040, "R6 hold");
    check("R6 hold value", prod_out, 32'h0000_0001);

    // R8: output follows prod_in mid-cycle
    @(negedge clk);
    prod_in = 32'h0000_0400;
    #1;
    check("R8 combinational follow", prod_out, 32'h0000_0010);

    // seeded random traffic
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) == 0, 16'($urandom), 1'($urandom), $urandom, "R2 R3 R4 R5 R6 R7 random");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule